// File: doc/BRIEF.md
# Integer PLL Control Register Lock Sequencer

This block is the register front end of an integer-divider PLL. Software writes three registers over a simple single-cycle bus: a lock-wait count, a divider configuration word (feedback multiplier M, reference pre-divider P, power-of-two post-divider S, and an enable bit), and a control word with a manual-control bit. The analog loop is not modelled. A countdown timer stands in for lock acquisition, and a status flag reports when the loop may be treated as settled.

A configuration write with the enable bit set starts a lock sequence. The timer loads from the lock-wait register and counts down once per reference clock. When it runs out, the lock flag rises, but only if the manual-control bit is set. Software normally programs the wait as 150 × P reference cycles before it writes the dividers. A configuration write with the enable bit clear stops any sequence and holds the flag low. The block also produces the output frequency word Fin × M / (P << S), with Fin a parameter given in kHz.

Top module: `pllctl_top`

## Requirements
- R1: After reset, every register reads 0, `pll_locked` is 0 and `freq_khz` is 0.
- R2: The configuration register (address 1) keeps M in bits 25:16, P in bits 13:8, S in bits 2:0 and enable in bit 31, and reads them back at those positions. Every other bit reads 0, except bit 29.
- R3: Bit 29 of the configuration register reads the lock flag. Writing it has no effect.
- R4: A configuration write with bit 31 set, accepted at edge E with lock-wait value L (address 0), makes `pll_locked` low through edge E+L and high from edge E+L+1, provided the manual bit is set.
- R5: A configuration write with bit 31 clear starts no lock sequence. `pll_locked` stays 0.
- R6: If control bit 1 (address 2) is clear when the count expires, `pll_locked` stays 0, and it stays 0 after the bit is later set, until the next configuration write.
- R7: `pll_locked` is 0 after the edge that accepts any configuration write, whether that write enables or disables the PLL.
- R8: A configuration write during a lock sequence restarts the count from the current lock-wait value.
- R9: A lock-wait value of 0, or P = 0, makes `pll_locked` rise at the edge after the write.
- R10: `freq_khz` equals FIN_KHZ × M / (P << S), truncated, or 0 when P = 0. It follows the register contents one edge later. A change of S alone also restarts the lock sequence.
- R11: The lock-wait register (address 0, low LOCK_W bits) and control bit 1 (address 2) read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 2 | Register select: 0 lock-wait, 1 configuration, 2 control |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pll_locked | output | 1 | Lock flag |
| freq_khz | output | FREQ_W | Computed output frequency in kHz |

## Verification
The hardest case to reach is a sequence that is interrupted or starved. Examples are a rewrite that lands partway through a count, a count that expires while manual control is off, and a change of S alone while the PLL is already locked. The bench programs a long lock-wait, idles a known number of cycles, then shortens the wait and rewrites the configuration. The scoreboard expects the flag exactly at the reloaded expiry, not at the original one. Starvation is covered by clearing the control bit before enabling. The bench then checks that the flag stays low long after expiry and that setting the bit afterwards does not raise it.

// File: rtl/pllctl_pkg.sv
package pllctl_pkg;
   localparam int unsigned DATA_W   = 32;
   localparam int unsigned M_W      = 10;
   localparam int unsigned P_W      = 6;
   localparam int unsigned S_W      = 3;
   localparam int unsigned M_LSB    = 16;
   localparam int unsigned P_LSB    = 8;
   localparam int unsigned S_LSB    = 0;
   localparam int unsigned EN_BIT   = 31;
   localparam int unsigned LOCK_BIT = 29;
   localparam int unsigned MAN_BIT  = 1;
   localparam int unsigned LOCK_PER_P = 150;

   typedef enum logic [1:0] {
      ADDR_WAIT = 2'd0,
      ADDR_CFG  = 2'd1,
      ADDR_CTRL = 2'd2,
      ADDR_NONE = 2'd3
   } reg_addr_e;

   typedef struct packed {
      logic           en;
      logic [M_W-1:0] m;
      logic [P_W-1:0] p;
      logic [S_W-1:0] s;
   } divcfg_t;
endpackage

// File: rtl/pllctl_regs.sv
module pllctl_regs
   import pllctl_pkg::*;
#(
   parameter int unsigned LOCK_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [1:0]        bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              lock_in,
   output logic [DATA_W-1:0] bus_rdata,
   output divcfg_t           cfg,
   output logic [LOCK_W-1:0] wait_cnt,
   output logic              manual,
   output logic              cfg_start,
   output logic              cfg_stop
);
   divcfg_t           cfg_q;
   logic [LOCK_W-1:0] wait_q;
   logic              man_q;
   logic              wr_cfg;
   reg_addr_e         addr;

   assign addr   = reg_addr_e'(bus_addr);
   assign wr_cfg = bus_wr && (addr == ADDR_CFG);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q  <= '0;
         wait_q <= '0;
         man_q  <= 1'b0;
      end else if (bus_wr) begin
         case (addr)
            ADDR_WAIT: wait_q <= bus_wdata[LOCK_W-1:0];
            ADDR_CFG: begin
               cfg_q.en <= bus_wdata[EN_BIT];
               cfg_q.m  <= bus_wdata[M_LSB +: M_W];
               cfg_q.p  <= bus_wdata[P_LSB +: P_W];
               cfg_q.s  <= bus_wdata[S_LSB +: S_W];
            end
            ADDR_CTRL: man_q <= bus_wdata[MAN_BIT];
            default: ;
         endcase
      end
   end

   always_comb begin
      bus_rdata = '0;
      case (addr)
         ADDR_WAIT: bus_rdata[LOCK_W-1:0] = wait_q;
         ADDR_CFG: begin
            bus_rdata[EN_BIT]          = cfg_q.en;
            bus_rdata[LOCK_BIT]        = lock_in;
            bus_rdata[M_LSB +: M_W]    = cfg_q.m;
            bus_rdata[P_LSB +: P_W]    = cfg_q.p;
            bus_rdata[S_LSB +: S_W]    = cfg_q.s;
         end
         ADDR_CTRL: bus_rdata[MAN_BIT] = man_q;
         default: bus_rdata = '0;
      endcase
   end

   assign cfg       = cfg_q;
   assign wait_cnt  = wait_q;
   assign manual    = man_q;
   assign cfg_start = wr_cfg && bus_wdata[EN_BIT];
   assign cfg_stop  = wr_cfg && !bus_wdata[EN_BIT];

   logic unused_wdata;
   assign unused_wdata = ^{bus_wdata[DATA_W-1:LOCK_W], bus_wdata[30:26],
                           bus_wdata[15:14], bus_wdata[7:3], bus_wdata[0]};

   // R2: after a configuration write the stored fields match the written data
   a_r2_fields: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cfg |=> (cfg_q.m == $past(bus_wdata[M_LSB +: M_W])) &&
                 (cfg_q.en == $past(bus_wdata[EN_BIT])));
endmodule

// File: rtl/pllctl_lock_timer.sv
module pllctl_lock_timer #(
   parameter int unsigned LOCK_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              stop,
   input  logic [LOCK_W-1:0] wait_cnt,
   input  logic              p_zero,
   input  logic              manual,
   output logic              locked
);
   logic [LOCK_W-1:0] cnt_q;
   logic              busy_q;
   logic              lock_q;
   logic              expire;

   assign expire = busy_q && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         busy_q <= 1'b0;
         lock_q <= 1'b0;
      end else if (start) begin
         cnt_q  <= p_zero ? '0 : wait_cnt;
         busy_q <= 1'b1;
         lock_q <= 1'b0;
      end else if (stop) begin
         cnt_q  <= '0;
         busy_q <= 1'b0;
         lock_q <= 1'b0;
      end else if (expire) begin
         busy_q <= 1'b0;
         lock_q <= manual;
      end else if (busy_q) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign locked = lock_q;

   // R7: any accepted configuration write clears the flag
   a_r7_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (start || stop) |=> !lock_q);
   // R6: the flag rises only when manual control was on
   a_r6_manual: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock_q) |-> $past(manual));
   // R5: a disabling write ends any sequence
   a_r5_stop: assert property (@(posedge clk) disable iff (!rst_n)
      stop |=> !busy_q);
   // R4: the count falls by one each cycle while running
   a_r4_count: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !start && !stop && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/pllctl_freq.sv
module pllctl_freq
   import pllctl_pkg::*;
#(
   parameter int unsigned FIN_KHZ  = 26000,
   parameter int unsigned FREQ_W   = 32,
   parameter bit          FREQ_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  divcfg_t           cfg,
   output logic [FREQ_W-1:0] freq
);
   localparam int unsigned PROD_W = FREQ_W + M_W;
   localparam int unsigned DEN_W  = P_W + (1 << S_W);

   logic [PROD_W-1:0] prod;
   logic [DEN_W-1:0]  den;
   logic [PROD_W-1:0] quot;
   logic [FREQ_W-1:0] f_next;

   assign prod   = PROD_W'(FIN_KHZ) * PROD_W'(cfg.m);
   assign den    = DEN_W'(cfg.p) << cfg.s;
   assign quot   = (cfg.p == '0) ? '0 : prod / PROD_W'(den);
   assign f_next = quot[FREQ_W-1:0];

   generate
      if (FREQ_REG) begin : g_reg
         logic [FREQ_W-1:0] f_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) f_q <= '0;
            else        f_q <= f_next;
         end
         assign freq = f_q;
         // R10: a zero pre-divider gives a zero frequency word
         a_r10_pzero: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg.p == '0) |=> (freq == '0));
      end else begin : g_comb
         assign freq = f_next;
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
      end
   endgenerate
endmodule

// File: rtl/pllctl_top.sv
module pllctl_top
   import pllctl_pkg::*;
#(
   parameter int unsigned LOCK_W   = 16,
   parameter int unsigned FIN_KHZ  = 26000,
   parameter int unsigned FREQ_W   = 32,
   parameter bit          FREQ_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [1:0]        bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              pll_locked,
   output logic [FREQ_W-1:0] freq_khz
);
   localparam int unsigned MIN_LOCK_W = $clog2(LOCK_PER_P * ((1 << P_W) - 1) + 1);

   generate
      if (LOCK_W < MIN_LOCK_W || LOCK_W > DATA_W) begin : g_bad_lock_w
         $error("LOCK_W must hold the largest lock wait");
      end
      if (FIN_KHZ == 0 || FREQ_W < 16) begin : g_bad_freq
         $error("FIN_KHZ must be nonzero and FREQ_W at least 16");
      end
   endgenerate

   divcfg_t           cfg;
   logic [LOCK_W-1:0] wait_cnt;
   logic              manual;
   logic              cfg_start;
   logic              cfg_stop;
   logic              locked;

   pllctl_regs #(.LOCK_W(LOCK_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .lock_in(locked), .bus_rdata(bus_rdata),
      .cfg(cfg), .wait_cnt(wait_cnt), .manual(manual),
      .cfg_start(cfg_start), .cfg_stop(cfg_stop)
   );

   pllctl_lock_timer #(.LOCK_W(LOCK_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .start(cfg_start), .stop(cfg_stop),
      .wait_cnt(wait_cnt), .p_zero(bus_wdata[P_LSB +: P_W] == '0),
      .manual(manual), .locked(locked)
   );

   pllctl_freq #(.FIN_KHZ(FIN_KHZ), .FREQ_W(FREQ_W), .FREQ_REG(FREQ_REG)) u_freq (
      .clk(clk), .rst_n(rst_n), .cfg(cfg), .freq(freq_khz)
   );

   assign pll_locked = locked;

   // R5: with the enable bit clear the flag is low
   a_r5_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg.en |-> !pll_locked);
endmodule

// File: tb/sim_pllctl_top.sv
module sim_pllctl_top;
   localparam int PERIOD = 10;
   localparam int WDOG   = 200000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [1:0]  bus_addr = 2'd0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        pll_locked;
   logic [31:0] freq_khz;

   pllctl_top u0 (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
                  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
                  .pll_locked(pll_locked), .freq_khz(freq_khz));

   always #(PERIOD/2) clk = ~clk;

   typedef struct {
      int          cyc;
      int          sel;
      logic [31:0] val;
      string       tag;
   } exp_t;

   exp_t sb[$];
   int   cyc = 0;
   int   n_chk = 0;
   int   n_err = 0;
   bit   done = 0;

   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [31:0] cfgw(bit en, int m, int p, int s);
      return {en, 1'b0, 1'b0, 3'b0, 10'(m), 2'b0, 6'(p), 5'b0, 3'(s)};
   endfunction

   task automatic expect_at(int c, int sel, logic [31:0] v, string tag);
      exp_t e;
      e.cyc = c; e.sel = sel; e.val = v; e.tag = tag;
      sb.push_back(e);
   endtask

   // monitor: pops expectations when their cycle comes up
   always @(negedge clk) begin
      for (int i = sb.size() - 1; i >= 0; i--) begin
         if (sb[i].cyc <= cyc) begin
            logic [31:0] act;
            act = (sb[i].sel == 0) ? {31'b0, pll_locked} : freq_khz;
            n_chk++;
            if (sb[i].cyc < cyc || act !== sb[i].val) begin
               n_err++;
               $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)",
                        sb[i].tag, act, sb[i].val, sb[i].cyc);
            end
            sb.delete(i);
         end
      end
   end

   task automatic wr(logic [1:0] a, logic [31:0] d, output int c);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      c = cyc;
      @(posedge clk);
      #1 bus_wr = 1'b0;
   endtask

   task automatic rd(logic [1:0] a, logic [31:0] e, string tag);
      @(negedge clk);
      bus_addr = a;
      #1;
      n_chk++;
      if (bus_rdata !== e) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", tag, bus_rdata, e);
      end
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #(PERIOD * WDOG);
      if (!done) begin
         n_err++; n_chk++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      int c;
      logic [31:0] cfg_a;
      cfg_a = cfgw(1, 100, 1, 2);
      idle(3);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset state
      rd(2'd0, 32'h0, "R1 wait reg");
      rd(2'd1, 32'h0, "R1 cfg reg");
      rd(2'd2, 32'h0, "R1 ctrl reg");
      expect_at(cyc + 1, 0, 0, "R1 lock");
      expect_at(cyc + 1, 1, 0, "R1 freq");
      idle(2);

      // R11 readback
      wr(2'd2, 32'h2, c);
      rd(2'd2, 32'h2, "R11 ctrl");
      wr(2'd0, 32'hFFFF_0000 | 32'd1950, c);
      rd(2'd0, 32'd1950, "R11 wait");

      // R4 R2 R10: 26 MHz, M=800 P=13 S=0
      wr(2'd1, cfgw(1, 800, 13, 0), c);
      expect_at(c + 1, 0, 0, "R7 lock low after write");
      expect_at(c + 2, 1, 1600000, "R10 freq 1600000");
      expect_at(c + 1 + 1950, 0, 0, "R4 lock low at wait end");
      expect_at(c + 2 + 1950, 0, 1, "R4 lock high after wait");
      rd(2'd1, 32'h8320_0D00, "R2 cfg readback while locking");
      idle(1960);
      rd(2'd1, 32'hA320_0D00, "R3 lock bit reads set");

      // R5 R3: disabled write with bit 29 set
      wr(2'd1, cfgw(0, 100, 1, 2) | 32'h2000_0000, c);
      expect_at(c + 1, 0, 0, "R7 lock drops on disable");
      expect_at(c + 2, 1, 650000, "R10 freq 650000");
      expect_at(c + 20, 0, 0, "R5 no lock when disabled");
      rd(2'd1, 32'h0064_0102, "R3 bit29 write ignored");
      idle(22);

      // R10: S-only change relocks
      wr(2'd0, 32'd5, c);
      wr(2'd1, cfg_a, c);
      expect_at(c + 7, 0, 1, "R4 lock wait 5");
      idle(9);
      wr(2'd1, cfgw(1, 100, 1, 1), c);
      expect_at(c + 1, 0, 0, "R10 S-only change drops lock");
      expect_at(c + 2, 1, 1300000, "R10 freq 1300000");
      expect_at(c + 6, 0, 0, "R10 S-only relock pending");
      expect_at(c + 7, 0, 1, "R10 S-only relock");
      idle(9);

      // R8 restart from new wait
      wr(2'd0, 32'd20, c);
      wr(2'd1, cfg_a, c);
      idle(10);
      wr(2'd0, 32'd4, c);
      wr(2'd1, cfg_a, c);
      expect_at(c + 5, 0, 0, "R8 restart lock pending");
      expect_at(c + 6, 0, 1, "R8 restart lock from new wait");
      idle(30);

      // R6 manual control off
      wr(2'd2, 32'h0, c);
      wr(2'd0, 32'd3, c);
      wr(2'd1, cfg_a, c);
      expect_at(c + 5, 0, 0, "R6 no lock at expiry");
      expect_at(c + 15, 0, 0, "R6 no lock later");
      idle(17);
      wr(2'd2, 32'h2, c);
      expect_at(c + 5, 0, 0, "R6 setting bit later does not lock");
      idle(6);
      rd(2'd1, 32'h8064_0102, "R6 lock bit reads clear");
      wr(2'd1, cfg_a, c);
      expect_at(c + 5, 0, 1, "R4 lock after manual restored");
      idle(7);

      // R9 zero wait, zero P
      wr(2'd0, 32'd0, c);
      wr(2'd1, cfg_a, c);
      expect_at(c + 1, 0, 0, "R9 zero wait low at accept");
      expect_at(c + 2, 0, 1, "R9 zero wait lock next");
      idle(4);
      wr(2'd0, 32'd50, c);
      wr(2'd1, cfgw(1, 100, 0, 0), c);
      expect_at(c + 2, 0, 1, "R9 P zero lock next");
      expect_at(c + 2, 1, 0, "R10 P zero freq 0");
      idle(4);

      // R7 disable while locked
      wr(2'd1, cfgw(0, 100, 0, 0), c);
      expect_at(c + 1, 0, 0, "R7 disable drops lock");
      idle(4);

      wait (sb.size() == 0);
      idle(2);
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule